// File: doc/BRIEF.md
# Oversampled SYSREF Edge Aligner

This block turns an asynchronous SYSREF timing pulse into a single-cycle pulse in the device-clock domain. Each cycle it receives four samples of SYSREF, taken at four evenly spaced phases of the device clock. Bit 0 holds the earliest phase and bit 3 the latest. The block finds the first rising transition among the previous cycle's last sample and the current four samples. This gives the edge position to a quarter of a cycle. It then assigns the edge to a device-clock cycle using a programmable decision window.

A 16-bit control register is loaded through a plain write port, and its value can be read on an output. The register sets:

- the window center,
- an offset of one cycle early, none, or one cycle late,
- whether status monitoring is on,
- a self-clearing clear of the statistics,
- a bypass mode. In bypass, SYSREF is taken from a single flop and every other alignment control is ignored.

While monitoring is on, the block reports the phase of each detected edge and keeps four saturating per-phase hit counters.

Top module: `sysref_aligner`

## Requirements
- R1: After reset, cfg_q reads 0x1000, sr_pulse is 0, edge_ph is 0 and all hit counters are 0.
- R2: A write stores cfg_wdata[15:14] as the window code, [13:12] as the offset code, [11] as monitor enable and [0] as bypass. Bits 10:1 always read back as 0, so writing 0xFFFF reads back 0xF801.
- R3: The edge phase k (0..3) is the lowest index i for which sample i is 1 and the sample just before it is 0. For i = 0, the sample just before is the previous cycle's bit 3. While monitoring is on and bypass is off, k appears on edge_ph after the capture edge, which is the clock edge that samples the vector.
- R4: Window code w sets a center c = w + 1. An edge with k >= c is assigned to the capture edge. An edge with k < c is assigned to the edge after it. Code 3 therefore always assigns to the next edge.
- R5: With offset code 01, and also with the reserved code 11, sr_pulse is high for exactly one cycle, immediately after the clock edge that follows the assigned edge.
- R6: Offset code 00 raises sr_pulse one edge earlier than R5. Offset code 10 raises it one edge later.
- R7: If SYSREF stays high over several cycles, only one pulse is produced. A further pulse needs the samples to go low first.
- R8: With bypass set, sr_pulse is high for one cycle right after the capture edge of a vector whose bit 0 is 1 when the previous bit 0 was 0. Window, offset and monitoring have no effect in this mode, and hit_cnt and edge_ph do not change.
- R9: While monitoring is on and bypass is off, each detected edge adds one to the counter hit_cnt[8k+7:8k] at the capture edge. While monitoring is off, no counter changes.
- R10: A counter at 255 stays at 255.
- R11: Writing a 1 to bit 1 zeroes all counters at the clock edge after the write. At that edge the clear wins over a coincident increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph_smp | input | 4 | SYSREF samples for this cycle; bit 0 is the earliest phase |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_q | output | 16 | Stored control register value |
| sr_pulse | output | 1 | Aligned single-cycle SYSREF pulse |
| edge_ph | output | 2 | Phase index of the last monitored edge |
| hit_cnt | output | 32 | Four 8-bit per-phase hit counters; phase k is in bits 8k+7:8k |

## Verification
The statistics clear and a counter increment can land on the same clock edge. To provoke this, the clear is written on the same edge that captures one edge (phase 0), and a second edge (phase 1) is fed on the following cycle. The counters must read all zero after that cycle: the first increment is wiped and the second is suppressed. A third edge one cycle later must then count normally, which shows that the clear lasts only one cycle.

// File: rtl/sysref_aligner.sv
module sysref_aligner #(
  parameter int          NPH     = 4,
  parameter int          CW      = 8,
  parameter logic [15:0] CFG_RST = 16'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPH-1:0]    ph_smp,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_q,
  output logic              sr_pulse,
  output logic [1:0]        edge_ph,
  output logic [NPH*CW-1:0] hit_cnt
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [1:0] win_q, off_q;
  logic       mon_q, byp_q, clr_q;
  logic       prev_last, byp_smp;
  logic       vnext, d1, d2, pulse_q;
  logic [1:0] ph_q;
  logic [CW-1:0] cnt [NPH];

  logic [NPH:0]   ext;
  logic [NPH-1:0] rise;
  logic           det, cur, ev_cur, ev_nxt, v, stat_en;
  logic [1:0]     k;
  logic           unused_bits;

  assign unused_bits = ^cfg_wdata[10:1];

  assign ext  = {ph_smp, prev_last};
  assign rise = ext[NPH:1] & ~ext[NPH-1:0];

  always_comb begin
    det = |rise;
    k   = '0;
    for (int i = NPH - 1; i >= 0; i--)
      if (rise[i]) k = i[1:0];
  end

  assign cur     = ({1'b0, k} >= ({1'b0, win_q} + 3'd1));
  assign ev_cur  = det & cur;
  assign ev_nxt  = det & ~cur;
  assign v       = ev_cur | vnext;
  assign stat_en = mon_q & ~byp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= CFG_RST[15:14];
      off_q <= CFG_RST[13:12];
      mon_q <= CFG_RST[11];
      byp_q <= CFG_RST[0];
      clr_q <= 1'b0;
    end else begin
      clr_q <= cfg_we & cfg_wdata[1];
      if (cfg_we) begin
        win_q <= cfg_wdata[15:14];
        off_q <= cfg_wdata[13:12];
        mon_q <= cfg_wdata[11];
        byp_q <= cfg_wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_last <= 1'b0;
      byp_smp   <= 1'b0;
      vnext     <= 1'b0;
      d1        <= 1'b0;
      d2        <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      prev_last <= ph_smp[NPH-1];
      byp_smp   <= ph_smp[0];
      vnext     <= ev_nxt;
      d1        <= v;
      d2        <= d1;
      if (byp_q) pulse_q <= ph_smp[0] & ~byp_smp;
      else begin
        case (off_q)
          2'b00:   pulse_q <= v;
          2'b10:   pulse_q <= d2;
          default: pulse_q <= d1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= '0;
      for (int i = 0; i < NPH; i++) cnt[i] <= '0;
    end else begin
      if (stat_en && det) ph_q <= k;
      for (int i = 0; i < NPH; i++) begin
        if (clr_q) cnt[i] <= '0;
        else if (stat_en && det && k == i[1:0] && cnt[i] != CMAX)
          cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NPH; g++) begin : g_cnt
      assign hit_cnt[g*CW +: CW] = cnt[g];

      p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[g] == CMAX && !clr_q) |=> cnt[g] == CMAX);
    end
  endgenerate

  assign cfg_q    = {win_q, off_q, mon_q, 10'd0, byp_q};
  assign sr_pulse = pulse_q;
  assign edge_ph  = ph_q;

  p_byp_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_q && $past(byp_q) && sr_pulse) |-> $past(ph_smp[0]));

  p_stats_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_en && !clr_q) |=> ($stable(hit_cnt) && $stable(edge_ph)));

  p_clear_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> hit_cnt == '0);

  p_one_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_q |=> $countones(hit_cnt ^ $past(hit_cnt)) <= CW + 1 || $past(clr_q));
endmodule

// File: tb/test_sysref_aligner.sv
`timescale 1ns/1ps
module test_sysref_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ph_smp = '0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_q;
  logic        sr_pulse;
  logic [1:0]  edge_ph;
  logic [31:0] hit_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sysref_aligner i_sysref_aligner (
    .clk(clk), .rst_n(rst_n), .ph_smp(ph_smp), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .sr_pulse(sr_pulse),
    .edge_ph(edge_ph), .hit_cnt(hit_cnt)
  );

  // {cfg, vector, pulse delay in edges after capture (15 = none), phase}
  // R4 entries 0..8, R6 entries 9..12, R5 entry 13, R8 entries 14..16, R3 entries 17..19
  localparam int NT = 20;
  localparam logic [25:0] TBL [NT] = '{
    {16'h1000, 4'b0001, 4'd2,  2'd0},
    {16'h1000, 4'b0010, 4'd1,  2'd1},
    {16'h1000, 4'b1000, 4'd1,  2'd3},
    {16'h5000, 4'b0010, 4'd2,  2'd1},
    {16'h5000, 4'b0100, 4'd1,  2'd2},
    {16'h9000, 4'b0100, 4'd2,  2'd2},
    {16'h9000, 4'b1000, 4'd1,  2'd3},
    {16'hD000, 4'b1000, 4'd2,  2'd3},
    {16'hD000, 4'b0001, 4'd2,  2'd0},
    {16'h0000, 4'b0010, 4'd0,  2'd1},
    {16'h0000, 4'b0001, 4'd1,  2'd0},
    {16'h2000, 4'b0010, 4'd2,  2'd1},
    {16'h2000, 4'b0001, 4'd3,  2'd0},
    {16'h3000, 4'b0010, 4'd1,  2'd1},
    {16'h1001, 4'b0001, 4'd0,  2'd0},
    {16'hD801, 4'b0001, 4'd0,  2'd0},
    {16'h1001, 4'b1110, 4'd15, 2'd0},
    {16'h1800, 4'b1110, 4'd1,  2'd1},
    {16'h1800, 4'b0110, 4'd1,  2'd1},
    {16'h1800, 4'b0101, 4'd2,  2'd0}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    @(negedge clk); ph_smp = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic edge_once(input logic [3:0] vec);
    @(negedge clk); ph_smp = vec;
    @(negedge clk); ph_smp = '0;
  endtask

  logic [15:0] t_cfg;
  logic [3:0]  t_vec, t_d;
  logic [1:0]  t_k, saved_ph;
  int          pcount, ppos;
  logic [31:0] saved_cnt;

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cfg", {16'd0, cfg_q}, 32'h1000);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 pulse", {31'd0, sr_pulse}, 0);
    chk("R1 edge_ph", {30'd0, edge_ph}, 0);
    chk("R1 hit_cnt", hit_cnt, 0);

    // R2 field storage and reserved bits
    wr(16'hFFFF);
    chk("R2 readback", {16'd0, cfg_q}, 32'hF801);
    wr(16'h1000);
    chk("R2 rewrite", {16'd0, cfg_q}, 32'h1000);

    for (int e = 0; e < NT; e++) begin
      {t_cfg, t_vec, t_d, t_k} = TBL[e];
      wr(t_cfg);
      idle(4);
      ph_smp = t_vec;
      pcount = 0; ppos = 15;
      @(posedge clk); #1;
      if (sr_pulse) begin pcount++; ppos = 0; end
      if (t_cfg[11] && !t_cfg[0]) chk($sformatf("R3 phase entry %0d", e), {30'd0, edge_ph}, {30'd0, t_k});
      @(negedge clk); ph_smp = '0;
      for (int i = 1; i < 6; i++) begin
        @(posedge clk); #1;
        if (sr_pulse) begin pcount++; if (ppos == 15) ppos = i; end
      end
      chk($sformatf("table(R4,R5,R6,R8) entry %0d count", e), pcount, (t_d == 15) ? 0 : 1);
      chk($sformatf("table(R4,R5,R6,R8) entry %0d delay", e), ppos, {28'd0, t_d});
    end

    // R7 held-high SYSREF yields one pulse, re-arms after going low
    wr(16'h1000);
    idle(4);
    for (int r = 0; r < 2; r++) begin
      pcount = 0;
      @(negedge clk); ph_smp = 4'hF;
      for (int i = 0; i < 5; i++) begin @(posedge clk); #1; if (sr_pulse) pcount++; end
      @(negedge clk); ph_smp = '0;
      for (int i = 0; i < 5; i++) begin @(posedge clk); #1; if (sr_pulse) pcount++; end
      chk($sformatf("R7 held high pass %0d", r), pcount, 1);
    end

    // R11 plain clear, then R9 per-phase accumulation
    wr(16'h1802);
    @(posedge clk); #1;
    chk("R11 cleared", hit_cnt, 0);
    edge_once(4'b0001); edge_once(4'b0010); edge_once(4'b0010);
    edge_once(4'b0100); edge_once(4'b1000);
    @(posedge clk); #1;
    chk("R9 histogram", hit_cnt, 32'h01010201);
    chk("R3 last phase", {30'd0, edge_ph}, 3);

    // R9 monitoring off: counters and phase untouched
    saved_cnt = hit_cnt; saved_ph = edge_ph;
    wr(16'h1000);
    edge_once(4'b0010); edge_once(4'b0001);
    @(posedge clk); #1;
    chk("R9 off counters", hit_cnt, saved_cnt);
    chk("R9 off phase", {30'd0, edge_ph}, {30'd0, saved_ph});

    // R8 bypass ignores monitoring
    wr(16'h1801);
    edge_once(4'b0010); idle(1); edge_once(4'b0001);
    @(posedge clk); #1;
    chk("R8 bypass counters", hit_cnt, saved_cnt);
    chk("R8 bypass phase", {30'd0, edge_ph}, {30'd0, saved_ph});

    // R10 saturation
    wr(16'h1802);
    for (int i = 0; i < 260; i++) edge_once(4'b0001);
    @(posedge clk); #1;
    chk("R10 saturate", hit_cnt, 32'h000000FF);

    // R11 clear coinciding with increments
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 16'h1802; ph_smp = 4'b0001;
    @(negedge clk); cfg_we = 1'b0; ph_smp = 4'b0010;
    @(posedge clk); #1;
    chk("R11 clear beats increment", hit_cnt, 0);
    @(negedge clk); ph_smp = 4'b0100;
    @(posedge clk); #1;
    chk("R11 count resumes", hit_cnt, 32'h00010000);
    idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule